// File: doc/BRIEF.md
# Serial Frame CRC-8 Checker

This block checks the integrity of a 64-bit frame that arrives one bit at a time, least significant bit first. The first 56 bits are seven payload bytes. They run through a bit-serial CRC-8 engine for the polynomial x^8 + x^5 + x^4 + 1. The engine works in reflected form and starts from zero. The last 8 bits are the reference CRC byte, which is shifted into its own register. After the 56th payload bit the computed value stops changing.

An upstream sequencer strobes each received bit in with `bit_en`. It pulses `frame_done` when it considers the frame over. If all 64 bits have been taken by then, the block latches `crc_ok` on the next clock edge. `crc_ok` stays latched until `clr` starts a new frame. With the parameter `CHECK_EN` set to 0, no comparison is made, and `crc_ok` only reports that a whole frame arrived.

The control is a four-state machine:
- ST_DATA accumulates payload bits. It moves to ST_REF on the last payload bit.
- ST_REF collects the reference byte. On the last bit it moves to ST_DONE if `frame_done` comes in the same cycle, and to ST_WAIT otherwise.
- ST_WAIT moves to ST_DONE on `frame_done`.
- ST_DONE holds.
- `clr` returns every state to ST_DATA.

Top module: `serial_crc8_check`

## Requirements
- R1: After reset, and in the cycle after `clr`, `crc_value` is 0x00 and `crc_ok` is 0.
- R2: Each accepted payload bit d updates the register as follows: f = crc[0] XOR d, shift right by one, then XOR 0x8C if f is 1. Payload bit k is bit k%8 of byte k/8, and bytes are sent in order from byte 0.
- R3: Once 56 payload bits have been accepted, `crc_value` no longer changes until `clr`.
- R4: Bits 57 to 64 form the reference byte, and bit 57 is its LSB. A single flipped reference bit makes the check fail.
- R5: With `CHECK_EN`=1, a `frame_done` pulse after all 64 bits sets `crc_ok` on the next edge exactly when the computed value equals the reference byte. `crc_ok` then stays high until `clr`.
- R6: A `frame_done` pulse before the 64th bit is ignored. `crc_ok` stays 0, and the frame continues to accept bits.
- R7: `bit_en` pulses after the 64th bit are ignored. They change neither `crc_value` nor the result.
- R8: `clr` takes priority over `bit_en` and `frame_done` in the same cycle. The bit is discarded.
- R9: If `frame_done` coincides with the 64th `bit_en`, the comparison includes that bit.
- R10: With `CHECK_EN`=0, `crc_ok` becomes 1 after `frame_done` following 64 bits, whatever the content.
- R11: With `CHECK_EN`=1, `crc_ok` is 1 exactly when running the same update over all 64 bits leaves a residue of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous start of a new frame |
| bit_en | input | 1 | Strobe that accepts `bit_in` |
| bit_in | input | 1 | Received serial bit, LSB first |
| frame_done | input | 1 | Pulse asking for the frame verdict |
| crc_value | output | CRC_W | CRC computed over the payload bits |
| crc_ok | output | 1 | Latched pass flag, or frame-complete flag when checking is disabled |

## Verification
Two events can land in the same edge: the verdict request (`frame_done`) and the capture of the final reference bit. The bench raises both in one cycle on every odd sweep value. It then expects the same pass result as a separate pulse would give, because the bit being shifted in must take part in the compare. A second collision, `clr` together with `bit_en` and `frame_done`, is provoked mid-frame. It is judged by a zeroed `crc_value`, and by a correct verdict on the complete frame that follows, which would be misaligned if the discarded bit had been counted.

// File: rtl/serial_crc8_pkg.sv
package serial_crc8_pkg;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_REF  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } chk_state_e;

endpackage

// File: rtl/crc8_serial_lfsr.sv
module crc8_serial_lfsr #(
    parameter int unsigned          CRC_W     = 8,
    parameter logic [CRC_W-1:0]     POLY_REFL = 8'h8C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q
);

    logic             fb;
    logic [CRC_W-1:0] crc_d;

    always_comb begin
        fb    = crc_q[0] ^ bit_in;
        crc_d = (crc_q >> 1) ^ (fb ? POLY_REFL : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc_q <= '0;
        else if (clr)     crc_q <= '0;
        else if (step_en) crc_q <= crc_d;
    end

endmodule

// File: rtl/frame_bit_counter.sv
module frame_bit_counter #(
    parameter int unsigned DATA_BITS  = 56,
    parameter int unsigned TOTAL_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_data,
    output logic last_total
);

    localparam int unsigned CNT_W = $clog2(TOTAL_BITS + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign last_data  = (cnt_q == CNT_W'(DATA_BITS - 1));
    assign last_total = (cnt_q == CNT_W'(TOTAL_BITS - 1));

endmodule

// File: rtl/ref_byte_capture.sv
module ref_byte_capture #(
    parameter int unsigned CRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] ref_q,
    output logic [CRC_W-1:0] ref_d
);

    // LSB-first arrival: new bit enters at the top and walks down.
    assign ref_d = {bit_in, ref_q[CRC_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ref_q <= '0;
        else if (clr)      ref_q <= '0;
        else if (shift_en) ref_q <= ref_d;
    end

endmodule

// File: rtl/serial_crc8_check.sv
module serial_crc8_check
    import serial_crc8_pkg::*;
#(
    parameter int unsigned      DATA_BITS = 56,
    parameter int unsigned      CRC_W     = 8,
    parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C,
    parameter bit               CHECK_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             frame_done,
    output logic [CRC_W-1:0] crc_value,
    output logic             crc_ok
);

    localparam int unsigned TOTAL_BITS = DATA_BITS + CRC_W;

    chk_state_e state_q, state_d;

    logic             in_data, in_ref, accept;
    logic             last_data, last_total;
    logic [CRC_W-1:0] ref_q, ref_d;
    logic             verdict_now;
    logic [CRC_W-1:0] ref_sel;
    logic             match;

    assign in_data = (state_q == ST_DATA);
    assign in_ref  = (state_q == ST_REF);
    assign accept  = bit_en && !clr && (in_data || in_ref);

    crc8_serial_lfsr #(
        .CRC_W     (CRC_W),
        .POLY_REFL (POLY_REFL)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .step_en (accept && in_data),
        .bit_in  (bit_in),
        .crc_q   (crc_value)
    );

    frame_bit_counter #(
        .DATA_BITS  (DATA_BITS),
        .TOTAL_BITS (TOTAL_BITS)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .inc        (accept),
        .last_data  (last_data),
        .last_total (last_total)
    );

    ref_byte_capture #(
        .CRC_W (CRC_W)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (accept && in_ref),
        .bit_in   (bit_in),
        .ref_q    (ref_q),
        .ref_d    (ref_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DATA;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_DATA;
        end else begin
            unique case (state_q)
                ST_DATA: if (bit_en && last_data) state_d = ST_REF;
                ST_REF:  if (bit_en && last_total)
                             state_d = frame_done ? ST_DONE : ST_WAIT;
                ST_WAIT: if (frame_done) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_DATA;
            endcase
        end
    end

    // Verdict request that completes the frame this cycle
    always_comb begin
        verdict_now = 1'b0;
        ref_sel     = ref_q;
        unique case (state_q)
            ST_REF: begin
                verdict_now = bit_en && last_total && frame_done;
                ref_sel     = ref_d;
            end
            ST_WAIT: verdict_now = frame_done;
            default: verdict_now = 1'b0;
        endcase
    end

    generate
        if (CHECK_EN) begin : g_compare
            assign match = (crc_value == ref_sel);
        end else begin : g_count_only
            assign match = 1'b1;
        end
    endgenerate

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           crc_ok <= 1'b0;
        else if (clr)         crc_ok <= 1'b0;
        else if (verdict_now) crc_ok <= match;
    end

endmodule

// File: rtl/serial_crc8_check_props.sv
module serial_crc8_check_props #(
    parameter int unsigned DATA_BITS = 56,
    parameter int unsigned CRC_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             bit_en,
    input logic             frame_done,
    input logic [CRC_W-1:0] crc_value,
    input logic             crc_ok
);

    localparam int unsigned TOTAL = DATA_BITS + CRC_W;
    localparam int unsigned CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             seen <= '0;
        else if (clr)                           seen <= '0;
        else if (bit_en && seen < CW'(TOTAL))   seen <= seen + 1'b1;
    end

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_value == '0 && !crc_ok));

    assert_crc_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= CW'(DATA_BITS) && !clr) |=> $stable(crc_value));

    assert_ok_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok && !clr) |=> crc_ok);

    assert_ok_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_ok) |-> $past(frame_done));

    assert_early_done_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_ok && frame_done && !clr && seen < CW'(TOTAL - 1)) |=> !crc_ok);

endmodule

bind serial_crc8_check serial_crc8_check_props #(
    .DATA_BITS (DATA_BITS),
    .CRC_W     (CRC_W)
) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .bit_en     (bit_en),
    .frame_done (frame_done),
    .crc_value  (crc_value),
    .crc_ok     (crc_ok)
);

// File: tb/test_serial_crc8_check.sv
module test_serial_crc8_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       frame_done = 1'b0;
    logic [7:0] crc_value, crc_nc;
    logic       crc_ok, ok_nc;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    serial_crc8_check i_serial_crc8_check (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en), .bit_in(bit_in),
        .frame_done(frame_done), .crc_value(crc_value), .crc_ok(crc_ok));

    serial_crc8_check #(.CHECK_EN(1'b0)) i_serial_crc8_check_nochk (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en), .bit_in(bit_in),
        .frame_done(frame_done), .crc_value(crc_nc), .crc_ok(ok_nc));

    function automatic logic [7:0] run_crc(input logic [63:0] f, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic fb = c[0] ^ f[i];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] make_frame(input int seed, input logic [7:0] b0);
        logic [63:0] f;
        int s = seed;
        f[7:0] = b0;
        for (int k = 1; k < 7; k++) begin
            s = (s * 1103515245 + 12345) & 32'h7fffffff;
            f[k*8 +: 8] = s[15:8];
        end
        f[63:56] = run_crc(f, 56);
        return f;
    endfunction

    task automatic check(input bit pass, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!pass) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic feed(input logic [63:0] f, input int start, input int stop,
                        input bit done_last);
        for (int i = start; i < stop; i++) begin
            bit_en     = 1'b1;
            bit_in     = f[i];
            frame_done = done_last && (i == stop - 1);
            @(negedge clk);
        end
        bit_en     = 1'b0;
        frame_done = 1'b0;
    endtask

    task automatic pulse_done();
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [63:0] base, f;
        logic [7:0]  frozen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(crc_value == 8'h00, "R1 reset crc_value", 64'(crc_value), 0);
        check(crc_ok == 1'b0, "R1 reset crc_ok", 64'(crc_ok), 0);

        // Sweep every value of payload byte 0 with a correct reference byte
        for (int v = 0; v < 256; v++) begin
            f = make_frame(v * 7 + 3, 8'(v));
            clear();
            feed(f, 0, 64, v[0]);            // R9: odd values raise done with bit 64
            if (!v[0]) pulse_done();
            check(crc_value == run_crc(f, 56), "R2 crc_value", 64'(crc_value), 64'(run_crc(f, 56)));
            check(crc_ok == 1'b1, v[0] ? "R9 coincident verdict" : "R5 good frame", 64'(crc_ok), 1);
            check(crc_ok == (run_crc(f, 64) == 8'h00), "R11 residue agrees",
                  64'(crc_ok), 64'(run_crc(f, 64) == 8'h00));
            check(ok_nc == 1'b1, "R10 count only", 64'(ok_nc), 1);
        end

        // Every single-bit error, data and reference
        base = make_frame(99, 8'h5A);
        for (int i = 0; i < 64; i++) begin
            f = base;
            f[i] = ~f[i];
            clear();
            feed(f, 0, 64, 1'b0);
            pulse_done();
            check(crc_ok == 1'b0, i >= 56 ? "R4 bad reference bit" : "R5 bad payload bit",
                  64'(crc_ok), 0);
            check(crc_ok == (run_crc(f, 64) == 8'h00), "R11 residue agrees",
                  64'(crc_ok), 64'(run_crc(f, 64) == 8'h00));
            check(ok_nc == 1'b1, "R10 count only bad frame", 64'(ok_nc), 1);
        end

        // R6 early verdict request
        clear();
        feed(base, 0, 30, 1'b0);
        pulse_done();
        check(crc_ok == 1'b0, "R6 early done", 64'(crc_ok), 0);
        feed(base, 30, 63, 1'b0);
        pulse_done();
        check(crc_ok == 1'b0, "R6 done at bit 63", 64'(crc_ok), 0);
        feed(base, 63, 64, 1'b0);
        pulse_done();
        check(crc_ok == 1'b1, "R6 frame continued", 64'(crc_ok), 1);

        // R3 freeze and R7 extra bits
        clear();
        feed(base, 0, 56, 1'b0);
        frozen = crc_value;
        check(frozen == run_crc(base, 56), "R2 after 56 bits", 64'(frozen), 64'(run_crc(base, 56)));
        feed(base, 56, 64, 1'b0);
        check(crc_value == frozen, "R3 frozen during reference", 64'(crc_value), 64'(frozen));
        feed(~base, 0, 5, 1'b0);
        check(crc_value == frozen, "R7 extra bits", 64'(crc_value), 64'(frozen));
        pulse_done();
        check(crc_ok == 1'b1, "R7 verdict unaffected", 64'(crc_ok), 1);
        feed(~base, 0, 9, 1'b0);
        pulse_done();
        check(crc_ok == 1'b1, "R5 stays latched", 64'(crc_ok), 1);

        // R1 clear after a pass
        clear();
        check(crc_value == 8'h00 && crc_ok == 1'b0, "R1 clear",
              {crc_value, 7'd0, crc_ok}, 0);

        // R8 clear beats bit_en and frame_done
        feed(base, 0, 20, 1'b0);
        clr = 1'b1; bit_en = 1'b1; bit_in = 1'b1; frame_done = 1'b1;
        @(negedge clk);
        clr = 1'b0; bit_en = 1'b0; frame_done = 1'b0;
        check(crc_value == 8'h00 && crc_ok == 1'b0, "R8 clear priority",
              {crc_value, 7'd0, crc_ok}, 0);
        feed(base, 0, 64, 1'b0);
        pulse_done();
        check(crc_ok == 1'b1, "R8 bit discarded", 64'(crc_ok), 1);
        clr = 1'b1; frame_done = 1'b1;
        @(negedge clk);
        clr = 1'b0; frame_done = 1'b0;
        check(crc_ok == 1'b0, "R8 clear with done", 64'(crc_ok), 0);

        summary();
    end

endmodule